// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a free-running 32-bit tick counter next to a 32-bit compare register and raises a timer interrupt when the counter lands on the compare value. The counter advances once per cycle in which the `tick_en` strobe is high. `tick_en` is normally a 100 MHz enable derived from the core clock. A control register can freeze the counter. The same register holds a 3-bit routing field that picks which of eight interrupt request lines carries the timer request.

Software uses a simple register port. The port is always ready: a write strobe with an address and data takes effect at the clock edge where it is sampled. Read data is a combinational function of the address. Because the port never stalls, there is no back-pressure, and a write can never be lost or delayed.

The interrupt is level-sensitive. Once raised, it stays up until software writes Compare. A pending status bit mirrors it when the `HAS_PENDING` parameter is 1.

Top module: `cct_timer`

## Requirements
- R1: After reset, Count reads 1, Compare reads 0, control reads 0, every `irq_lines` bit is 0 and `pending` is 0.
- R2: In each cycle with `tick_en` high and the counter not frozen, Count increases by exactly 1 at the clock edge. Count wraps from 0xFFFFFFFF to 0. Without `tick_en`, Count holds its value.
- R3: A write to address 0 loads Count at that edge. This load overrides an increment in the same cycle, and it works even while the counter is frozen.
- R4: While control bit 0 (freeze) is 1, Count ignores `tick_en`. After freeze is cleared, counting resumes from the value that was held.
- R5: When Count takes a new value, by increment or by write, that equals Compare while the counter is not frozen, the interrupt is raised at that same edge. It shows on the selected line and on `pending` in the cycle in which Count first reads the matching value.
- R6: The raised interrupt stays asserted while Count moves on past the match value.
- R7: Any write to address 1 (Compare) drops the interrupt and `pending` at that edge. This clearing wins over a match in the same cycle.
- R8: Control bits [3:1] select the line. When the interrupt is active, only `irq_lines[route]` is 1. Changing the route moves the request to the new line.
- R9: While frozen, no interrupt is raised, even when Count is written to the Compare value.
- R10: With `HAS_PENDING`=1, the `pending` output and status bit 0 at address 3 equal the interrupt state. With `HAS_PENDING`=0, both read 0.
- R11: Writes to address 3 (status) have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 Count, 1 Compare, 2 control, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_lines | output | 8 | Routed interrupt request lines |
| pending | output | 1 | Timer interrupt pending status |

## Verification
A corrupted counter shows up on the next read of address 0. The bench reads back on every clock, so it also shows as an interrupt that appears or vanishes at the wrong cycle, one edge after the bad increment or load. A wrong interrupt flag or route is visible on `irq_lines` and `pending` in the cycle after the faulty edge. The per-clock model comparison catches it within one clock. Directed sequences aim at the wrap, the load-over-increment priority, the Compare write that coincides with a match, and matches attempted while frozen.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_COUNT   = 2'd0,
    A_COMPARE = 2'd1,
    A_CTRL    = 2'd2,
    A_STATUS  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             freeze,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             upd
);
  logic inc;

  assign inc = tick && !freeze;
  assign upd = ld || inc;

  always_comb begin
    if (ld)       cnt_nxt = ld_val;
    else if (inc) cnt_nxt = cnt_q + CNT_W'(1);
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RESET_VAL;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/cct_match.sv
module cct_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             freeze,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic             ack,
  output logic             irq_q
);
  logic hit;

  assign hit = upd && !freeze && (cnt_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (ack) irq_q <= 1'b0;
    else if (hit) irq_q <= 1'b1;
  end
endmodule

// File: rtl/cct_router.sv
module cct_router #(
  parameter int NUM_LINES = 8,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 irq,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_LINES-1:0] lines
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign lines[i] = irq && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NUM_LINES   = 8,
  parameter bit HAS_PENDING = 1'b1,
  parameter logic [CNT_W-1:0] RESET_COUNT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic [NUM_LINES-1:0] irq_lines,
  output logic                 pending
);
  localparam int SEL_W = $clog2(NUM_LINES);

  logic             wr_cnt, wr_cmp, wr_ctrl;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cmp_q;
  logic             upd, irq_q, freeze_q;
  logic [SEL_W-1:0] route_q;

  assign wr_cnt  = reg_we && (reg_addr == A_COUNT);
  assign wr_cmp  = reg_we && (reg_addr == A_COMPARE);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      freeze_q <= 1'b0;
      route_q  <= '0;
    end else begin
      if (wr_cmp) cmp_q <= reg_wdata;
      if (wr_ctrl) begin
        freeze_q <= reg_wdata[0];
        route_q  <= reg_wdata[SEL_W:1];
      end
    end
  end

  cct_counter #(.CNT_W(CNT_W), .RESET_VAL(RESET_COUNT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .freeze  (freeze_q),
    .ld      (wr_cnt),
    .ld_val  (reg_wdata),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .upd     (upd)
  );

  cct_match #(.CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .freeze  (freeze_q),
    .cnt_nxt (cnt_nxt),
    .cmp_q   (cmp_q),
    .ack     (wr_cmp),
    .irq_q   (irq_q)
  );

  cct_router #(.NUM_LINES(NUM_LINES)) u_route (
    .irq   (irq_q),
    .sel   (route_q),
    .lines (irq_lines)
  );

  if (HAS_PENDING) begin : g_pend
    assign pending = irq_q;
  end else begin : g_nopend
    assign pending = 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_COUNT:   reg_rdata = cnt_q;
      A_COMPARE: reg_rdata = cmp_q;
      A_CTRL:    begin
        reg_rdata[0]       = freeze_q;
        reg_rdata[SEL_W:1] = route_q;
      end
      default:   reg_rdata[0] = pending;
    endcase
  end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int CNT_W       = 32,
  parameter int NUM_LINES   = 8,
  parameter bit HAS_PENDING = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 reg_we,
  input logic [1:0]           reg_addr,
  input logic [CNT_W-1:0]     reg_wdata,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 pending,
  input logic [CNT_W-1:0]     cnt_q,
  input logic                 freeze_q
);
  logic cnt_wr, cmp_wr;
  assign cnt_wr = reg_we && (reg_addr == 2'd0);
  assign cmp_wr = reg_we && (reg_addr == 2'd1);

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !freeze_q && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(reg_wdata)));

  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !cnt_wr) |=> $stable(cnt_q));

  p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_lines) && !cmp_wr) |=> (|irq_lines));

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (irq_lines == '0) && !pending);

  p_frozen_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !(|irq_lines)) |=> !(|irq_lines));

  p_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending == (HAS_PENDING ? (|irq_lines) : 1'b0));
endmodule

bind cct_timer cct_timer_chk #(
  .CNT_W(CNT_W), .NUM_LINES(NUM_LINES), .HAS_PENDING(HAS_PENDING)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_lines (irq_lines),
  .pending   (pending),
  .cnt_q     (cnt_q),
  .freeze_q  (freeze_q)
);

// File: tb/tb_cct_timer.sv
module tb_cct_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_lines;
  logic        pending;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cct_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lines(irq_lines), .pending(pending)
  );

  // behavioural reference
  logic [31:0] m_cnt, m_cmp;
  logic        m_irq, m_frz;
  logic [2:0]  m_route;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 32'd1; m_cmp = '0; m_irq = 1'b0; m_frz = 1'b0; m_route = '0;
    end else begin
      logic [31:0] nc;
      logic        moved;
      nc = m_cnt;
      moved = 1'b0;
      if (reg_we && reg_addr == 2'd0) begin nc = reg_wdata; moved = 1'b1; end
      else if (tick_en && !m_frz) begin nc = m_cnt + 1; moved = 1'b1; end
      if (reg_we && reg_addr == 2'd1) m_irq = 1'b0;
      else if (moved && !m_frz && nc == m_cmp) m_irq = 1'b1;
      if (reg_we && reg_addr == 2'd1) m_cmp = reg_wdata;
      if (reg_we && reg_addr == 2'd2) begin
        m_frz = reg_wdata[0]; m_route = reg_wdata[3:1];
      end
      m_cnt = nc;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_cmp;
      2'd2: return {28'd0, m_route, m_frz};
      default: return {31'd0, m_irq};
    endcase
  endfunction

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check({24'd0, irq_lines}, m_irq ? (32'd1 << m_route) : 32'd0, "R5 model irq_lines");
      check({31'd0, pending}, {31'd0, m_irq}, "R10 model pending");
      check(reg_rdata, m_rd(reg_addr), "R2 model readback");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; tick_en = tk;
    @(negedge clk);
    reg_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata, exp, tag);
  endtask

  task automatic irq_is(input logic [7:0] exp, input string tag);
    check({24'd0, irq_lines}, {24'd0, exp}, tag);
    check({31'd0, pending}, {31'd0, |exp}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, 32'd1, "R1 count reset");
    rd(2'd1, 32'd0, "R1 compare reset");
    rd(2'd2, 32'd0, "R1 ctrl reset");
    irq_is(8'h00, "R1 irq reset");

    ticks(10);
    rd(2'd0, 32'd11, "R2 ten ticks");

    wr(2'd2, 32'hA, 1'b0);                  // route 5
    wr(2'd1, 32'd20, 1'b0);
    wr(2'd0, 32'd18, 1'b0);
    ticks(1);
    rd(2'd0, 32'd19, "R2 one tick");
    irq_is(8'h00, "R5 no early match");
    ticks(1);
    rd(2'd0, 32'd20, "R5 count at match");
    irq_is(8'h20, "R5 R8 match on line 5");
    ticks(3);
    rd(2'd0, 32'd23, "R6 count past match");
    irq_is(8'h20, "R6 level held");
    wr(2'd3, 32'd0, 1'b0);
    rd(2'd3, 32'd1, "R11 status write ignored");
    irq_is(8'h20, "R11 irq unchanged");
    wr(2'd2, 32'hE, 1'b0);                  // route 7
    irq_is(8'h80, "R8 route change");
    wr(2'd1, 32'd100, 1'b0);
    irq_is(8'h00, "R7 compare write clears");

    wr(2'd0, 32'd99, 1'b1);
    rd(2'd0, 32'd99, "R3 load beats increment");
    ticks(1);
    irq_is(8'h80, "R5 match by increment");
    wr(2'd1, 32'd200, 1'b0);
    wr(2'd0, 32'd199, 1'b0);
    wr(2'd1, 32'd200, 1'b1);
    rd(2'd0, 32'd200, "R2 tick during compare write");
    irq_is(8'h00, "R7 clear wins over match");
    ticks(2);
    rd(2'd0, 32'd202, "R2 two ticks");

    wr(2'd2, 32'hF, 1'b0);                  // freeze, route 7
    ticks(5);
    rd(2'd0, 32'd202, "R4 frozen hold");
    wr(2'd1, 32'd300, 1'b0);
    wr(2'd0, 32'd300, 1'b0);
    rd(2'd0, 32'd300, "R3 load while frozen");
    irq_is(8'h00, "R9 no match while frozen");
    ticks(3);
    irq_is(8'h00, "R9 still quiet");
    wr(2'd2, 32'hE, 1'b0);
    ticks(1);
    rd(2'd0, 32'd301, "R4 resume from held value");

    wr(2'd1, 32'd0, 1'b0);
    wr(2'd0, 32'hFFFF_FFFE, 1'b0);
    ticks(3);
    rd(2'd0, 32'd1, "R2 wrap");
    irq_is(8'h80, "R5 match at zero after wrap");
    rd(2'd3, 32'd1, "R10 status bit");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule